// File: doc/BRIEF.md
# Greedy Round-Robin Warp Scheduler

This block decides which of the resident warps is allowed to fetch in the current cycle. Each warp slot supplies one eligibility bit, which upstream logic raises only when that warp is in its ready state, has no pending register dependency and has a free collector entry. The scheduler answers in the same cycle with a grant flag and the index of the chosen warp. Every warp's context stays resident, so moving from one warp to another costs no cycles.

Internally the block keeps a rotating search pointer and a record of the warp it granted last. If the last-granted warp is the only eligible one, it is granted again. Otherwise the slots are scanned in ascending circular order, starting at the pointer, and the first eligible slot wins. After every grant the pointer moves to the slot after the winner, wrapping from the highest slot back to zero. The slot count is a parameter and need not be a power of two; the default is 24.

Top module: `warp_sched`

## Requirements
- R1: After reset the search pointer is 0 and no warp counts as current, so with every warp eligible the first grant goes to warp 0.
- R2: The grant flag is high in a cycle exactly when at least one eligibility bit is high in that cycle; while the flag is low the grant index reads 0.
- R3: A granted index always names a warp whose eligibility bit is high in the same cycle, and it is below the slot count.
- R4: When a search is needed, the grant goes to the first eligible slot found scanning upward from the pointer and wrapping past the last slot to slot 0.
- R5: After a grant of warp g the pointer holds g+1, except that a grant of the last slot (23 by default) sets it to 0.
- R6: A cycle with no eligible warp leaves the pointer and the current-warp record unchanged.
- R7: While the most recently granted warp is the only eligible warp, it is granted in every cycle.
- R8: With every warp eligible in every cycle, grants run 0, 1, 2 up to the last slot and then start again at 0.
- R9: Eligibility is honoured in the cycle it is presented, and a different warp may be granted in the cycle right after a grant, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| elig_i | input | NUM_WARPS | One eligibility bit per warp slot |
| grant_valid_o | output | 1 | A warp is granted this cycle |
| grant_id_o | output | ID_W | Index of the granted warp, 0 when no grant |

## Verification
A corrupted search pointer shows at the very next cycle in which two or more warps are eligible, because the winner then depends on where the scan starts; sweeping every start position against every single and every pair of eligible warps exposes a wrong pointer or a wrong wrap within one grant. A lost or wrong current-warp record shows only when exactly one warp is eligible, and the pointer arithmetic makes the hold path agree with the scan, so the weight lies on the scan and the pointer update. Idle cycles are mixed into random runs so that a pointer that drifts while nothing is granted shows at the next contested grant.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  localparam int unsigned WS_WARPS = 24;
  localparam int unsigned WS_ID_W  = $clog2(WS_WARPS);

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HOLD = 2'd1,
    SRC_SCAN = 2'd2
  } grant_src_e;

endpackage

// File: rtl/wsched_circ_inc.sv
module wsched_circ_inc #(
  parameter int unsigned NUM_WARPS = 24,
  parameter int unsigned ID_W      = 5
) (
  input  logic [ID_W-1:0] val_i,
  output logic [ID_W-1:0] next_o
);

  localparam logic [ID_W-1:0] LAST_SLOT = ID_W'(NUM_WARPS - 1);

  // Wrap by comparison against the last slot; the slot count need not be 2^n.
  always_comb begin
    if (val_i == LAST_SLOT) begin
      next_o = '0;
    end else begin
      next_o = val_i + 1'b1;
    end
  end

endmodule

// File: rtl/wsched_scan.sv
module wsched_scan #(
  parameter int unsigned NUM_WARPS = 24,
  parameter int unsigned ID_W      = 5
) (
  input  logic [NUM_WARPS-1:0] elig_i,
  input  logic [ID_W-1:0]      ptr_i,
  output logic                 found_o,
  output logic [ID_W-1:0]      id_o
);

  localparam int unsigned SUM_W = ID_W + 1;
  localparam logic [SUM_W-1:0] SLOTS = SUM_W'(NUM_WARPS);

  logic [ID_W-1:0]      lane_idx [NUM_WARPS];
  logic [NUM_WARPS-1:0] lane_hit;

  // One lane per scan offset: lane k looks at slot (ptr + k) mod NUM_WARPS.
  for (genvar k = 0; k < NUM_WARPS; k++) begin : g_lane
    logic [SUM_W-1:0] raw_sum;
    logic [SUM_W-1:0] wrapped;

    always_comb begin
      raw_sum = {1'b0, ptr_i} + SUM_W'(k);
      if (raw_sum >= SLOTS) begin
        wrapped = raw_sum - SLOTS;
      end else begin
        wrapped = raw_sum;
      end
    end

    assign lane_idx[k] = wrapped[ID_W-1:0];
    assign lane_hit[k] = elig_i[lane_idx[k]];
  end

  // Lowest offset wins: walk from the far end so nearer lanes overwrite.
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    for (int k = NUM_WARPS - 1; k >= 0; k--) begin
      if (lane_hit[k]) begin
        found_o = 1'b1;
        id_o    = lane_idx[k];
      end
    end
  end

endmodule

// File: rtl/wsched_hold.sv
module wsched_hold #(
  parameter int unsigned NUM_WARPS = 24,
  parameter int unsigned ID_W      = 5
) (
  input  logic [NUM_WARPS-1:0] elig_i,
  input  logic [ID_W-1:0]      cur_id_i,
  input  logic                 cur_vld_i,
  output logic                 hold_o
);

  logic [NUM_WARPS-1:0] cur_sel;

  for (genvar i = 0; i < NUM_WARPS; i++) begin : g_dec
    assign cur_sel[i] = cur_vld_i && (cur_id_i == ID_W'(i));
  end

  logic cur_ready;
  logic other_ready;

  always_comb begin
    cur_ready   = |(elig_i & cur_sel);
    other_ready = |(elig_i & ~cur_sel);
    hold_o      = cur_ready && !other_ready;
  end

endmodule

// File: rtl/warp_sched.sv
module warp_sched
  import wsched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = WS_WARPS,
  parameter int unsigned ID_W      = WS_ID_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] elig_i,
  output logic                 grant_valid_o,
  output logic [ID_W-1:0]      grant_id_o
);

  // State registers
  logic [ID_W-1:0] rr_ptr_q;
  logic [ID_W-1:0] rr_ptr_d;
  logic [ID_W-1:0] cur_id_q;
  logic [ID_W-1:0] cur_id_d;
  logic            cur_vld_q;
  logic            cur_vld_d;
  logic            state_en;

  // Datapath
  logic            scan_found;
  logic [ID_W-1:0] scan_id;
  logic            hold_hit;
  logic [ID_W-1:0] ptr_after;
  grant_src_e      src;

  wsched_scan #(
    .NUM_WARPS (NUM_WARPS),
    .ID_W      (ID_W)
  ) i_scan (
    .elig_i  (elig_i),
    .ptr_i   (rr_ptr_q),
    .found_o (scan_found),
    .id_o    (scan_id)
  );

  wsched_hold #(
    .NUM_WARPS (NUM_WARPS),
    .ID_W      (ID_W)
  ) i_hold (
    .elig_i    (elig_i),
    .cur_id_i  (cur_id_q),
    .cur_vld_i (cur_vld_q),
    .hold_o    (hold_hit)
  );

  wsched_circ_inc #(
    .NUM_WARPS (NUM_WARPS),
    .ID_W      (ID_W)
  ) i_inc (
    .val_i  (grant_id_o),
    .next_o (ptr_after)
  );

  // Source selection: greedy hold first, then circular search.
  always_comb begin
    if (hold_hit) begin
      src = SRC_HOLD;
    end else if (scan_found) begin
      src = SRC_SCAN;
    end else begin
      src = SRC_NONE;
    end
  end

  always_comb begin
    unique case (src)
      SRC_HOLD: begin
        grant_valid_o = 1'b1;
        grant_id_o    = cur_id_q;
      end
      SRC_SCAN: begin
        grant_valid_o = 1'b1;
        grant_id_o    = scan_id;
      end
      default: begin
        grant_valid_o = 1'b0;
        grant_id_o    = '0;
      end
    endcase
  end

  // Next state: only a grant moves the pointer and the current record.
  always_comb begin
    state_en  = grant_valid_o;
    rr_ptr_d  = ptr_after;
    cur_id_d  = grant_id_o;
    cur_vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr_q  <= '0;
      cur_id_q  <= '0;
      cur_vld_q <= 1'b0;
    end else if (state_en) begin
      rr_ptr_q  <= rr_ptr_d;
      cur_id_q  <= cur_id_d;
      cur_vld_q <= cur_vld_d;
    end
  end

endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
  parameter int unsigned NUM_WARPS = 24,
  parameter int unsigned ID_W      = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WARPS-1:0] elig,
  input logic                 gvalid,
  input logic [ID_W-1:0]      gid,
  input logic [ID_W-1:0]      ptr,
  input logic [ID_W-1:0]      cur_id,
  input logic                 cur_vld
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  logic [NUM_WARPS-1:0] cur_onehot;
  assign cur_onehot = {{(NUM_WARPS-1){1'b0}}, 1'b1} << cur_id;

  p_valid_any_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gvalid == (|elig));

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !gvalid |-> (gid == '0));

  p_grant_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gvalid |-> (elig[gid] && (gid < ID_W'(NUM_WARPS))));

  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < ID_W'(NUM_WARPS));

  p_ptr_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(gvalid)) |->
      (ptr == (($past(gid) == ID_W'(NUM_WARPS - 1)) ? '0 : $past(gid) + 1'b1)));

  p_idle_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(gvalid)) |-> ($stable(ptr) && $stable(cur_id) && $stable(cur_vld)));

  p_hold_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_vld && (elig == cur_onehot)) |-> (gvalid && (gid == cur_id)));

endmodule

bind warp_sched warp_sched_chk #(
  .NUM_WARPS (NUM_WARPS),
  .ID_W      (ID_W)
) i_warp_sched_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .elig    (elig_i),
  .gvalid  (grant_valid_o),
  .gid     (grant_id_o),
  .ptr     (rr_ptr_q),
  .cur_id  (cur_id_q),
  .cur_vld (cur_vld_q)
);

// File: tb/test_warp_sched.sv
module test_warp_sched;

  localparam int N = 24;
  localparam int W = 5;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] elig;
  logic         gvalid;
  logic [W-1:0] gid;

  int checks;
  int errors;
  int mptr;
  bit done;

  warp_sched #(.NUM_WARPS(N), .ID_W(W)) i_warp_sched (
    .clk           (clk),
    .rst_n         (rst_n),
    .elig_i        (elig),
    .grant_valid_o (gvalid),
    .grant_id_o    (gid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int pick(logic [N-1:0] e, int p);
    for (int k = 0; k < N; k++) begin
      if (e[(p + k) % N]) return (p + k) % N;
    end
    return -1;
  endfunction

  // Drive at the falling edge, compare 1 ns later, model the pointer update.
  task automatic step(input logic [N-1:0] e, input string tag);
    int exp_id;
    @(negedge clk);
    elig = e;
    #1;
    exp_id = pick(e, mptr);
    checks++;
    if (exp_id < 0) begin
      if (gvalid !== 1'b0 || gid !== '0) begin
        errors++;
        $display("FAIL %s: valid=%0b id=%0d expected valid=0 id=0", tag, gvalid, gid);
      end
    end else begin
      if (gvalid !== 1'b1 || int'(gid) != exp_id) begin
        errors++;
        $display("FAIL %s: valid=%0b id=%0d expected valid=1 id=%0d", tag, gvalid, gid, exp_id);
      end
      mptr = (exp_id + 1) % N;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    mptr   = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    elig   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: first grant after reset with every warp eligible is warp 0
    step({N{1'b1}}, "R1");
    if (mptr != 1) begin
      errors++;
      $display("FAIL R1: model pointer %0d expected 1", mptr);
    end

    // R8 and R9: full rotation twice, a new warp every cycle
    for (int i = 0; i < 2 * N; i++) step({N{1'b1}}, "R8");

    // R2 and R6: idle cycles then a contested grant from the saved pointer
    for (int i = 0; i < 5; i++) step('0, "R2");
    step({N{1'b1}}, "R6");

    // R7: a lone eligible warp is granted again and again
    for (int i = 0; i < 20; i++) step(N'(1) << 5, "R7");
    step(N'(1) << 5 | N'(1) << 2, "R4");

    // R5: wrap from the last slot back to 0
    step(N'(1) << (N - 1), "R5");
    step({N{1'b1}}, "R5");

    // R3 and R4: every pointer start against every single eligible warp
    for (int p = 0; p < N; p++) begin
      for (int w = 0; w < N; w++) begin
        step(N'(1) << ((p + N - 1) % N), "R5");
        step(N'(1) << w, "R3");
      end
    end

    // R4: every pointer start against every pair of eligible warps
    for (int p = 0; p < N; p++) begin
      for (int a = 0; a < N; a++) begin
        for (int b = a + 1; b < N; b++) begin
          step(N'(1) << ((p + N - 1) % N), "R5");
          step((N'(1) << a) | (N'(1) << b), "R4");
        end
      end
    end

    // R9 and R6: random dense and sparse patterns with idle cycles mixed in
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] r;
      r = N'($urandom);
      if (i % 3 == 1) r = r & N'($urandom) & N'($urandom);
      if (i % 11 == 5) r = '0;
      step(r, "R9");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule